// File: doc/BRIEF.md
# Stream-to-Channel Deinterleaving Unpacker

This block turns one interleaved sample stream into a set of parallel channel outputs. Samples arrive on an AXI4-Stream slave port, several samples per beat. A downstream consumer pulls data with a single read request that is shared by every channel, and switches each channel on or off with its own enable bit. The stream carries samples only for the enabled channels. They are packed back to back in ascending channel order, so the lowest enabled channel receives the oldest sample of each group.

Incoming beats go into a small shifting sample buffer. Each request takes exactly as many samples as there are enabled channels. Any samples left over stay in the buffer for the next request, so a group of samples can span two beats. One cycle after a request, the block raises either a valid pulse, with every enabled channel holding its sample, or an underflow pulse when the buffer held too few samples at the time of the request. A beat that arrives in the same cycle as a request does not count toward that request.

Top module: `stream_unpacker`

## Requirements
- R1: After a synchronous active-high reset, rd_valid and rd_underflow are low and s_tready is high, because the buffer is empty.
- R2: A request made when the buffer holds at least as many samples as there are enabled channels gives an rd_valid pulse in the next cycle and no underflow.
- R3: A request made when the buffer holds fewer samples than there are enabled channels gives an rd_underflow pulse in the next cycle and no valid. It consumes no sample, so the next successful request returns the same samples.
- R4: Within a beat, sample j sits in s_tdata bits [j*SAMPLE_W +: SAMPLE_W], and sample 0 is the oldest. On valid, the enabled channel with the k-th lowest index (k counted from 0) carries the k-th oldest buffered sample on rd_data[ch*SAMPLE_W +: SAMPLE_W].
- R5: Leftover samples carry over between requests, and a request may span beat boundaries. Across any run of requests, the delivered samples form the same unbroken sequence that was accepted on the stream.
- R6: s_tready is high exactly when the buffered sample count plus BEAT_SAMPLES does not exceed the buffer depth (NUM_CH + BEAT_SAMPLES). A beat offered while s_tready is low is not taken.
- R7: On a valid cycle, every disabled channel reads zero.
- R8: In the cycle after a cycle with no request, rd_valid and rd_underflow are both low.
- R9: A request with all enables low always produces valid and consumes no sample.
- R10: rd_valid and rd_underflow are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | BEAT_SAMPLES*SAMPLE_W | Stream beat; sample 0 in the low bits |
| s_tvalid | input | 1 | Stream beat offered |
| s_tready | output | 1 | Buffer has room for a full beat |
| rd_req | input | 1 | Shared read request |
| ch_enable | input | NUM_CH | Per-channel enable, sampled with rd_req |
| rd_valid | output | 1 | Channel data valid (one cycle after a granted request) |
| rd_underflow | output | 1 | Request could not be served (one cycle after it) |
| rd_data | output | NUM_CH*SAMPLE_W | Channel samples, channel c in bits [c*SAMPLE_W +: SAMPLE_W] |

## Verification
The hardest case to reach from the ports is a request whose group of samples is split between the leftovers of one beat and the start of the next. This happens while the buffer is nearly full and s_tready is toggling, and it has to happen under every enable mask. The stimulus steps through all sixteen masks of a four-channel build, using two-sample beats, with requests and pushes issued together so the fill level drifts through odd offsets. Separate scenarios first fill the buffer until backpressure appears, then drain it until underflow appears. Each scenario checks that the sample sequence carries on unbroken once the stream resumes.

// File: rtl/upk_pkg.sv
package upk_pkg;

  // Widest enable mask the helper functions accept (NUM_CH must stay below this).
  localparam int UPK_MAX_CH = 256;

  // Number of set bits in a mask.
  function automatic int upk_ones(input logic [UPK_MAX_CH-1:0] m);
    int n;
    n = 0;
    for (int i = 0; i < UPK_MAX_CH; i++) begin
      if (m[i]) n++;
    end
    return n;
  endfunction

  // Position of channel ch among the enabled channels (enabled bits below it).
  function automatic int upk_rank(input logic [UPK_MAX_CH-1:0] m, input int ch);
    int n;
    n = 0;
    for (int i = 0; i < UPK_MAX_CH; i++) begin
      if (i < ch && m[i]) n++;
    end
    return n;
  endfunction

  // Width of a counter that holds 0..depth.
  function automatic int upk_cnt_w(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/upk_sample_buf.sv
module upk_sample_buf #(
  parameter int SAMPLE_W     = 8,
  parameter int BEAT_SAMPLES = 4,
  parameter int DEPTH        = 12,
  parameter int CNT_W        = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            pop_en,
  input  logic [CNT_W-1:0]                pop_cnt,
  input  logic                            push_en,
  input  logic [BEAT_SAMPLES*SAMPLE_W-1:0] push_data,
  output logic [CNT_W-1:0]                fill,
  output logic [DEPTH*SAMPLE_W-1:0]       slots
);

  logic [SAMPLE_W-1:0] slot_q [DEPTH];
  logic [SAMPLE_W-1:0] slot_d [DEPTH];
  logic [CNT_W-1:0]    fill_q;
  logic [CNT_W-1:0]    fill_d;
  int                  pop_amt;
  int                  base;

  // Oldest sample sits in slot 0; a pop shifts the remainder down,
  // a push appends a beat behind whatever survives the pop.
  always_comb begin
    pop_amt = pop_en ? int'(pop_cnt) : 0;
    base    = int'(fill_q) - pop_amt;
    for (int i = 0; i < DEPTH; i++) begin
      if (i + pop_amt < DEPTH) slot_d[i] = slot_q[i + pop_amt];
      else                     slot_d[i] = '0;
      for (int j = 0; j < BEAT_SAMPLES; j++) begin
        if (push_en && (i == base + j))
          slot_d[i] = push_data[j*SAMPLE_W +: SAMPLE_W];
      end
    end
    fill_d = CNT_W'(base + (push_en ? BEAT_SAMPLES : 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      fill_q <= fill_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign fill = fill_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign slots[g*SAMPLE_W +: SAMPLE_W] = slot_q[g];
  end

endmodule

// File: rtl/upk_ctrl.sv
module upk_ctrl #(
  parameter int NUM_CH       = 8,
  parameter int BEAT_SAMPLES = 4,
  parameter int DEPTH        = 12,
  parameter int CNT_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [NUM_CH-1:0] enable,
  input  logic [CNT_W-1:0]  fill,
  output logic              grant,
  output logic [CNT_W-1:0]  need,
  output logic              s_ready,
  output logic              rd_valid,
  output logic              rd_underflow
);
  import upk_pkg::*;

  logic [UPK_MAX_CH-1:0] en_wide;
  logic                  starve;

  assign en_wide = {{(UPK_MAX_CH-NUM_CH){1'b0}}, enable};
  assign need    = CNT_W'(upk_ones(en_wide));
  assign grant   = rd_req && (fill >= need);
  assign starve  = rd_req && !grant;
  assign s_ready = (int'(fill) + BEAT_SAMPLES) <= DEPTH;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      rd_underflow <= 1'b0;
    end else begin
      rd_valid     <= grant;
      rd_underflow <= starve;
    end
  end

endmodule

// File: rtl/upk_route.sv
module upk_route #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        grant,
  input  logic [NUM_CH-1:0]           enable,
  input  logic [DEPTH*SAMPLE_W-1:0]   slots,
  output logic [NUM_CH*SAMPLE_W-1:0]  rd_data
);
  import upk_pkg::*;

  logic [UPK_MAX_CH-1:0] en_wide;
  assign en_wide = {{(UPK_MAX_CH-NUM_CH){1'b0}}, enable};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    int                  rank;
    logic [SAMPLE_W-1:0] pick;

    always_comb begin
      rank = upk_rank(en_wide, c);
      pick = slots[rank*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)
        rd_data[c*SAMPLE_W +: SAMPLE_W] <= '0;
      else if (grant)
        rd_data[c*SAMPLE_W +: SAMPLE_W] <= enable[c] ? pick : '0;
    end
  end

endmodule

// File: rtl/stream_unpacker.sv
module stream_unpacker #(
  parameter int NUM_CH       = 8,
  parameter int SAMPLE_W     = 8,
  parameter int BEAT_SAMPLES = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [BEAT_SAMPLES*SAMPLE_W-1:0] s_tdata,
  input  logic                             s_tvalid,
  output logic                             s_tready,
  input  logic                             rd_req,
  input  logic [NUM_CH-1:0]                ch_enable,
  output logic                             rd_valid,
  output logic                             rd_underflow,
  output logic [NUM_CH*SAMPLE_W-1:0]       rd_data
);

  localparam int DEPTH = NUM_CH + BEAT_SAMPLES;
  localparam int CNT_W = upk_pkg::upk_cnt_w(DEPTH);

  logic [CNT_W-1:0]          fill_w;
  logic [CNT_W-1:0]          need_w;
  logic                      grant_w;
  logic                      push_w;
  logic [DEPTH*SAMPLE_W-1:0] slots_w;

  assign push_w = s_tvalid && s_tready;

  upk_ctrl #(
    .NUM_CH(NUM_CH), .BEAT_SAMPLES(BEAT_SAMPLES), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .enable(ch_enable), .fill(fill_w),
    .grant(grant_w), .need(need_w), .s_ready(s_tready),
    .rd_valid(rd_valid), .rd_underflow(rd_underflow)
  );

  upk_sample_buf #(
    .SAMPLE_W(SAMPLE_W), .BEAT_SAMPLES(BEAT_SAMPLES), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst(rst), .pop_en(grant_w), .pop_cnt(need_w),
    .push_en(push_w), .push_data(s_tdata), .fill(fill_w), .slots(slots_w)
  );

  upk_route #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)
  ) u_route (
    .clk(clk), .rst(rst), .grant(grant_w), .enable(ch_enable),
    .slots(slots_w), .rd_data(rd_data)
  );

endmodule

// File: rtl/upk_checker.sv
module upk_checker #(
  parameter int BEAT_SAMPLES = 4,
  parameter int DEPTH        = 12,
  parameter int CNT_W        = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic             rd_valid,
  input logic             rd_underflow,
  input logic             s_tready,
  input logic             push,
  input logic             grant,
  input logic [CNT_W-1:0] fill
);

  AST_NO_DOUBLE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_underflow)); // R10

  AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req)); // R2

  AST_GRANT_THEN_VALID: assert property (@(posedge clk) disable iff (rst)
    grant |=> rd_valid); // R2

  AST_UFLOW_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_underflow |-> $past(rd_req)); // R3

  AST_STARVE_THEN_UFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !grant) |=> rd_underflow); // R3

  AST_STARVE_KEEPS_FILL: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !grant && !push) |=> $stable(fill)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && !rd_underflow)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH); // R6

  AST_READY_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    s_tready |-> (int'(fill) + BEAT_SAMPLES <= DEPTH)); // R6

endmodule

bind stream_unpacker upk_checker #(
  .BEAT_SAMPLES(BEAT_SAMPLES), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_upk_checker (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_underflow(rd_underflow), .s_tready(s_tready), .push(push_w),
  .grant(grant_w), .fill(fill_w)
);

// File: tb/tb_stream_unpacker.sv
module tb_stream_unpacker;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int SW   = 8;
  localparam int BS   = 2;
  localparam int DEP  = NCH + BS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [BS*SW-1:0]  s_tdata = '0;
  logic              s_tvalid = 1'b0;
  logic              s_tready;
  logic              rd_req = 1'b0;
  logic [NCH-1:0]    ch_enable = '0;
  logic              rd_valid;
  logic              rd_underflow;
  logic [NCH*SW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  // Bench model of the stream and buffer.
  int in_seq  = 0;
  int out_seq = 0;
  int m_fill  = 0;
  logic [NCH-1:0] mask = '0;

  // Expectation for the cycle after the last driven one.
  bit             p_req   = 0;
  bit             p_avail = 0;
  int             p_base  = 0;
  logic [NCH-1:0] p_mask  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_unpacker #(.NUM_CH(NCH), .SAMPLE_W(SW), .BEAT_SAMPLES(BS)) dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .rd_req(rd_req), .ch_enable(ch_enable),
    .rd_valid(rd_valid), .rd_underflow(rd_underflow), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ones4(input logic [NCH-1:0] m);
    int n = 0;
    for (int i = 0; i < NCH; i++) n += m[i] ? 1 : 0;
    return n;
  endfunction

  // Compare outputs against the request made in the previous cycle.
  task automatic check_pending();
    bit exp_v, exp_u;
    int r;
    exp_v = p_req && p_avail;
    exp_u = p_req && !p_avail;
    chk(rd_valid == exp_v, (p_req && ones4(p_mask) == 0) ? "R9" : (p_req ? "R2" : "R8"),
        int'(rd_valid), int'(exp_v));
    chk(rd_underflow == exp_u, p_req ? "R3" : "R8", int'(rd_underflow), int'(exp_u));
    chk(!(rd_valid && rd_underflow), "R10", int'(rd_valid && rd_underflow), 0);
    if (exp_v) begin
      r = 0;
      for (int c = 0; c < NCH; c++) begin
        if (p_mask[c]) begin
          chk(rd_data[c*SW +: SW] == SW'(p_base + r), "R4/R5",
              int'(rd_data[c*SW +: SW]), int'(SW'(p_base + r)));
          r++;
        end else begin
          chk(rd_data[c*SW +: SW] == '0, "R7", int'(rd_data[c*SW +: SW]), 0);
        end
      end
    end
  endtask

  // One clock: check the last result, drive new inputs, advance the model.
  task automatic cycle(input bit req, input bit push);
    bit acc, avail;
    int cnt;
    @(negedge clk);
    check_pending();
    rd_req    = req;
    ch_enable = mask;
    s_tvalid  = push;
    for (int j = 0; j < BS; j++) s_tdata[j*SW +: SW] = SW'(in_seq + j);
    #1;
    chk(s_tready == (m_fill + BS <= DEP), "R6", int'(s_tready), int'(m_fill + BS <= DEP));
    acc   = push && s_tready;
    cnt   = ones4(mask);
    avail = m_fill >= cnt;
    p_req = req; p_avail = avail; p_mask = mask; p_base = out_seq;
    if (req && avail) begin
      out_seq += cnt;
      m_fill  -= cnt;
    end
    if (acc) begin
      in_seq += BS;
      m_fill += BS;
    end
    @(posedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1; rd_req = 1'b0; s_tvalid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_fill = 0; out_seq = in_seq; p_req = 0;
    #1;
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    chk(rd_underflow == 1'b0, "R1", int'(rd_underflow), 0);
    chk(s_tready == 1'b1, "R1", int'(s_tready), 1);
    @(posedge clk);
  endtask

  task automatic test_idle();
    mask = 4'b1011;
    repeat (2) cycle(1'b0, 1'b1);
    repeat (3) cycle(1'b0, 1'b0);   // R8: quiet outputs
  endtask

  task automatic test_all_masks();
    for (int m = 0; m < 16; m++) begin
      mask = NCH'(m);
      repeat (5) cycle(1'b1, 1'b1);
      cycle(1'b1, 1'b0);
      cycle(1'b0, 1'b1);
      cycle(1'b1, 1'b0);
    end
  endtask

  task automatic test_starve();
    mask = 4'b1111;
    repeat (5) cycle(1'b1, 1'b0);   // R3: drain then underflow
    cycle(1'b1, 1'b1);              // push in same cycle does not help request
    cycle(1'b0, 1'b1);
    repeat (2) cycle(1'b1, 1'b0);   // R5: sequence continues after underflow
    mask = 4'b0000;
    repeat (2) cycle(1'b1, 1'b0);   // R9: empty mask always served
  endtask

  task automatic test_backpressure();
    mask = 4'b0101;
    repeat (6) cycle(1'b0, 1'b1);   // R6: fill until ready drops
    repeat (3) cycle(1'b1, 1'b1);
    mask = 4'b1110;
    repeat (6) cycle(1'b1, 1'b1);   // R5: groups spanning beats
    repeat (4) cycle(1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_idle();
    test_all_masks();
    test_starve();
    test_backpressure();
    test_reset();
    test_starve();
    cycle(1'b0, 1'b0);
    @(negedge clk);
    check_pending();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule